// File: doc/BRIEF.md
# Remote Terminal Status Word Builder

This block assembles the 16-bit status word that a command/response bus remote terminal returns after each command. When the protocol engine asks for a status update, the block samples the subsystem's active-low condition inputs (busy, service request, subsystem flag, terminal flag). It merges them with conditions tracked inside the block: the message error, the broadcast-received state, and the dynamic-bus-control acceptance. The result is held in a register and marked on the parallel bus by an active-low enable window.

Alongside the word, the block keeps the per-command context latched at the start of each new protocol sequence. It also keeps a sticky active-low message-error output and gates the data-transfer request so that a busy subsystem is not asked for transmit data. It issues the active-low good-block pulse once a clean receive block has been handed to the subsystem. Serial encoding of the word is handled elsewhere.

Top module: `rt_status_builder`

## Requirements
- R1: After reset the status word is all zeros and the outputs status_en_n, msg_err_n, good_blk_n and xfer_req_n are high (with xfer_want low).
- R2: In the cycle after status_load is high, status_word holds term_addr in bits 15:11 and the following single-bit fields. Service request is bit 8, busy is bit 3, subsystem flag is bit 2 and terminal flag is bit 0. Each of these bits is 1 when its active-low input was low at the update and 0 when it was high. Bits 9 and 7:5 are always 0.
- R3: illegal_n is captured only on a rising edge of in_cmd. A captured low sets the message-error bit (bit 10) at the next update, and the capture is cleared by cmd_start. Changes on illegal_n at any other time have no effect, and illegal_n never drives msg_err_n.
- R4: msg_err_n goes low in the cycle after a msg_err_evt pulse and stays low until the cycle after the next cmd_start. While the error is held, an update sets bit 10.
- R5: The dynamic-bus-control acceptance bit is set at an update when dbca_n is low and the latched command is a mode command (cmd_mode) of the dynamic-bus-control type (cmd_dbc). The command must also be neither broadcast nor captured as illegal. In every other case bit 1 is 0.
- R6: Broadcast-received (bit 4) is 1 at an update after a cmd_start with cmd_bcast high. It returns to 0 after a cmd_start with cmd_bcast low.
- R7: xfer_req_n is the inverse of xfer_want, except that it is held high while the latched command is a transmit command (cmd_tx = 1) and the busy bit of the status word is set. Receive commands are never blocked.
- R8: After an rx_block_done pulse, good_blk_n goes low for GOOD_BLK_CYC cycles, starting in the next cycle. This happens only when the latched command is a receive (cmd_tx = 0), non-mode command with no held message error and no illegal capture. Otherwise good_blk_n stays high.
- R9: status_en_n goes low for STAT_EN_CYC cycles, starting in the cycle after status_load. The status word keeps its value in every cycle without status_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_addr | input | ADDR_W | Assigned terminal address |
| busy_n | input | 1 | Subsystem busy, active low |
| srq_n | input | 1 | Service request, active low |
| ssflag_n | input | 1 | Subsystem flag, active low |
| tflag_n | input | 1 | Terminal flag, active low |
| illegal_n | input | 1 | Illegal-command indication, active low |
| dbca_n | input | 1 | Accept dynamic bus control, active low |
| in_cmd | input | 1 | High while a command is being serviced |
| cmd_start | input | 1 | One-cycle pulse at start of a new protocol sequence |
| cmd_tx | input | 1 | Command is transmit (latched at cmd_start) |
| cmd_mode | input | 1 | Command is a mode command (latched) |
| cmd_dbc | input | 1 | Mode code is dynamic bus control (latched) |
| cmd_bcast | input | 1 | Command is broadcast (latched) |
| msg_err_evt | input | 1 | Pulse on a format or word error |
| status_load | input | 1 | Pulse requesting a status word update |
| xfer_want | input | 1 | Protocol engine needs a data transfer |
| rx_block_done | input | 1 | Pulse when a receive block has been transferred |
| status_word | output | WORD_W | Assembled status word |
| status_en_n | output | 1 | Status word on the parallel bus, active low |
| msg_err_n | output | 1 | Sticky message error, active low |
| good_blk_n | output | 1 | Good-block pulse, active low |
| xfer_req_n | output | 1 | Data-transfer request, active low |

## Verification
The bench toggles illegal_n while in_cmd stays high to confirm that only the rising edge captures it. A design that sampled the level would wrongly report a message error. The bench asks for data on a transmit command with busy set, then on a receive command, so a design that blocked both directions or neither is caught. Dynamic-bus-control acceptance is tried with a non-DBC mode code and with a broadcast DBC command, where a loose decode would set bit 1. Good-block is tried after transmit, mode and errored receive commands, where a missing qualifier would fire the pulse. The widths of both enable windows are counted cycle by cycle, which exposes off-by-one counters.

// File: rtl/rtsw_pkg.sv
package rtsw_pkg;

   // Status word field positions (the bus controller decodes these)
   localparam int unsigned ADDR_LSB = 11;
   localparam int unsigned ME_BIT   = 10;
   localparam int unsigned SRQ_BIT  = 8;
   localparam int unsigned BCR_BIT  = 4;
   localparam int unsigned BUSY_BIT = 3;
   localparam int unsigned SSF_BIT  = 2;
   localparam int unsigned DBCA_BIT = 1;
   localparam int unsigned TF_BIT   = 0;

   // Active-low subsystem condition inputs, grouped
   typedef struct packed {
      logic srq;
      logic busy;
      logic ssf;
      logic tf;
   } sub_flags_t;

   // Command context latched at the start of a protocol sequence
   typedef struct packed {
      logic tx;
      logic mode;
      logic dbc;
      logic bcast;
   } cmd_info_t;

endpackage

// File: rtl/rtsw_pulse_gen.sv
module rtsw_pulse_gen #(
   parameter int unsigned LEN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic pulse_n
);

   if (LEN == 0) begin : g_bad_len
      $error("rtsw_pulse_gen: LEN must be at least 1");
   end

   if (LEN == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_n <= 1'b1;
         else        pulse_n <= ~trig;
      end
   end else begin : g_count
      localparam int unsigned CW = $clog2(LEN + 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt <= '0;
         else if (trig)         cnt <= CW'(LEN);
         else if (cnt != '0)    cnt <= cnt - CW'(1);
      end

      assign pulse_n = (cnt == '0);
   end

   // Shared by the good-block (R8) and status-enable (R9) windows
   p_trig_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(trig) |-> !pulse_n);

endmodule

// File: rtl/rtsw_cmd_track.sv
module rtsw_cmd_track
   import rtsw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cmd_start,
   input  cmd_info_t cmd_in,
   input  logic      in_cmd,
   input  logic      illegal_n,
   input  logic      msg_err_evt,
   output cmd_info_t cmd_q,
   output logic      illegal_q,
   output logic      err_q
);

   logic in_cmd_d;
   logic in_cmd_rise;

   assign in_cmd_rise = in_cmd & ~in_cmd_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cmd_d  <= 1'b0;
         cmd_q     <= '0;
         illegal_q <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         in_cmd_d <= in_cmd;
         if (cmd_start) cmd_q <= cmd_in;
         // illegal indication is only looked at on in_cmd rising edge
         if (in_cmd_rise)    illegal_q <= ~illegal_n;
         else if (cmd_start) illegal_q <= 1'b0;
         // a new error wins over the clear from a new sequence
         if (msg_err_evt)    err_q <= 1'b1;
         else if (cmd_start) err_q <= 1'b0;
      end
   end

   p_ill_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(in_cmd_rise) && !$past(cmd_start)) |-> $stable(illegal_q));

   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(err_q) && !$past(cmd_start)) |-> err_q);

   p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(msg_err_evt) |-> err_q);

   p_bcast_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_start) |-> (cmd_q.bcast == $past(cmd_in.bcast)));

endmodule

// File: rtl/rtsw_word_reg.sv
module rtsw_word_reg
   import rtsw_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr,
   input  sub_flags_t        flags_n,
   input  logic              me_bit,
   input  logic              bcr_bit,
   input  logic              dbca_bit,
   output logic [WORD_W-1:0] word
);

   if (WORD_W != ADDR_LSB + ADDR_W) begin : g_bad_layout
      $error("rtsw_word_reg: address field must end at the word MSB");
   end

   logic [WORD_W-1:0] nxt;

   always_comb begin
      nxt                     = '0;
      nxt[ADDR_LSB +: ADDR_W] = addr;
      nxt[ME_BIT]             = me_bit;
      nxt[SRQ_BIT]            = ~flags_n.srq;
      nxt[BCR_BIT]            = bcr_bit;
      nxt[BUSY_BIT]           = ~flags_n.busy;
      nxt[SSF_BIT]            = ~flags_n.ssf;
      nxt[DBCA_BIT]           = dbca_bit;
      nxt[TF_BIT]             = ~flags_n.tf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word <= '0;
      else if (load) word <= nxt;
   end

   p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> $stable(word));

   p_flag_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> (word[SRQ_BIT] == !$past(flags_n.srq) &&
                       word[BUSY_BIT] == !$past(flags_n.busy) &&
                       word[TF_BIT] == !$past(flags_n.tf)));

endmodule

// File: rtl/rt_status_builder.sv
module rt_status_builder
   import rtsw_pkg::*;
#(
   parameter int unsigned ADDR_W       = 5,
   parameter int unsigned WORD_W       = 16,
   parameter int unsigned GOOD_BLK_CYC = 6,
   parameter int unsigned STAT_EN_CYC  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] term_addr,
   input  logic              busy_n,
   input  logic              srq_n,
   input  logic              ssflag_n,
   input  logic              tflag_n,
   input  logic              illegal_n,
   input  logic              dbca_n,
   input  logic              in_cmd,
   input  logic              cmd_start,
   input  logic              cmd_tx,
   input  logic              cmd_mode,
   input  logic              cmd_dbc,
   input  logic              cmd_bcast,
   input  logic              msg_err_evt,
   input  logic              status_load,
   input  logic              xfer_want,
   input  logic              rx_block_done,
   output logic [WORD_W-1:0] status_word,
   output logic              status_en_n,
   output logic              msg_err_n,
   output logic              good_blk_n,
   output logic              xfer_req_n
);

   if (ADDR_W != 5 || WORD_W != 16) begin : g_bad_size
      $error("rt_status_builder: layout fixed at 5-bit address, 16-bit word");
   end

   cmd_info_t  cmd_in;
   cmd_info_t  cmd_q;
   sub_flags_t flags_n;
   logic       illegal_q;
   logic       err_q;
   logic       dbca_ok;
   logic       gb_trig;
   logic       tx_blocked;

   assign cmd_in  = {cmd_tx, cmd_mode, cmd_dbc, cmd_bcast};
   assign flags_n = {srq_n, busy_n, ssflag_n, tflag_n};

   rtsw_cmd_track u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_start   (cmd_start),
      .cmd_in      (cmd_in),
      .in_cmd      (in_cmd),
      .illegal_n   (illegal_n),
      .msg_err_evt (msg_err_evt),
      .cmd_q       (cmd_q),
      .illegal_q   (illegal_q),
      .err_q       (err_q)
   );

   // acceptance needs a legal, addressed DBC mode command
   assign dbca_ok = ~dbca_n & cmd_q.mode & cmd_q.dbc & ~cmd_q.bcast & ~illegal_q;

   rtsw_word_reg #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W)
   ) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (status_load),
      .addr     (term_addr),
      .flags_n  (flags_n),
      .me_bit   (err_q | illegal_q),
      .bcr_bit  (cmd_q.bcast),
      .dbca_bit (dbca_ok),
      .word     (status_word)
   );

   rtsw_pulse_gen #(.LEN(STAT_EN_CYC)) u_stat_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (status_load),
      .pulse_n (status_en_n)
   );

   assign gb_trig = rx_block_done & ~cmd_q.tx & ~cmd_q.mode & ~illegal_q & ~err_q;

   rtsw_pulse_gen #(.LEN(GOOD_BLK_CYC)) u_good_blk (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (gb_trig),
      .pulse_n (good_blk_n)
   );

   assign msg_err_n  = ~err_q;
   assign tx_blocked = cmd_q.tx & status_word[BUSY_BIT];
   assign xfer_req_n = ~(xfer_want & ~tx_blocked);

   p_gb_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(good_blk_n) |-> ($past(rx_block_done) && !$past(cmd_q.tx)));

   p_se_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_en_n) |-> $past(status_load));

   p_dbca_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_load) && status_word[DBCA_BIT]) |->
         ($past(cmd_q.mode) && $past(cmd_q.dbc) && !$past(dbca_n)));

   p_rx_not_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_want && !cmd_q.tx) |-> !xfer_req_n);

endmodule

// File: tb/rt_status_builder_tb_top.sv
module rt_status_builder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  term_addr;
   logic        busy_n, srq_n, ssflag_n, tflag_n, illegal_n, dbca_n;
   logic        in_cmd, cmd_start, cmd_tx, cmd_mode, cmd_dbc, cmd_bcast;
   logic        msg_err_evt, status_load, xfer_want, rx_block_done;
   logic [15:0] status_word;
   logic        status_en_n, msg_err_n, good_blk_n, xfer_req_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   rt_status_builder dut_i (
      .clk (clk), .rst_n (rst_n), .term_addr (term_addr),
      .busy_n (busy_n), .srq_n (srq_n), .ssflag_n (ssflag_n), .tflag_n (tflag_n),
      .illegal_n (illegal_n), .dbca_n (dbca_n), .in_cmd (in_cmd),
      .cmd_start (cmd_start), .cmd_tx (cmd_tx), .cmd_mode (cmd_mode),
      .cmd_dbc (cmd_dbc), .cmd_bcast (cmd_bcast), .msg_err_evt (msg_err_evt),
      .status_load (status_load), .xfer_want (xfer_want),
      .rx_block_done (rx_block_done), .status_word (status_word),
      .status_en_n (status_en_n), .msg_err_n (msg_err_n),
      .good_blk_n (good_blk_n), .xfer_req_n (xfer_req_n)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(input logic [4:0] a, input bit me,
      input bit srq, input bit bcr, input bit bsy, input bit ssf,
      input bit dbca, input bit tf);
      return {a, me, 1'b0, srq, 3'b000, bcr, bsy, ssf, dbca, tf};
   endfunction

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_load();
      status_load = 1'b1; step(); status_load = 1'b0;
   endtask

   task automatic new_cmd(input bit tx, input bit md, input bit dbc, input bit bc);
      cmd_tx = tx; cmd_mode = md; cmd_dbc = dbc; cmd_bcast = bc;
      cmd_start = 1'b1; step(); cmd_start = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "status_word", status_word, 16'h0000);
      chk("R1", "status_en_n", status_en_n, 1);
      chk("R1", "msg_err_n", msg_err_n, 1);
      chk("R1", "good_blk_n", good_blk_n, 1);
      chk("R1", "xfer_req_n", xfer_req_n, 1);
   endtask

   task automatic t_flags();
      term_addr = 5'h15; srq_n = 0; busy_n = 1; ssflag_n = 0; tflag_n = 1;
      pulse_load();
      chk("R2", "word pattern A", status_word, exp_word(5'h15, 0, 1, 0, 0, 1, 0, 0));
      term_addr = 5'h0A; srq_n = 1; busy_n = 0; ssflag_n = 1; tflag_n = 0;
      step(3);
      chk("R9", "word held without update", status_word,
          exp_word(5'h15, 0, 1, 0, 0, 1, 0, 0));
      pulse_load();
      chk("R2", "word pattern B", status_word, exp_word(5'h0A, 0, 0, 0, 1, 0, 0, 1));
      busy_n = 1; tflag_n = 1;
      pulse_load();
      chk("R2", "word flags clear", status_word, exp_word(5'h0A, 0, 0, 0, 0, 0, 0, 0));
   endtask

   task automatic t_stat_en();
      int lows = 0;
      step(8);
      pulse_load();
      chk("R9", "status_en_n low after load", status_en_n, 0);
      for (int i = 0; i < 10; i++) begin
         if (!status_en_n) lows++;
         step();
      end
      chk("R9", "status_en_n window", lows, 6);
   endtask

   task automatic t_illegal();
      in_cmd = 0; new_cmd(0, 0, 0, 0);
      illegal_n = 0; in_cmd = 1; step();
      illegal_n = 1; step();
      pulse_load();
      chk("R3", "ME bit after illegal capture", status_word[10], 1);
      chk("R3", "msg_err_n untouched by illegal", msg_err_n, 1);
      in_cmd = 0; step();
      new_cmd(0, 0, 0, 0);
      illegal_n = 1; in_cmd = 1; step();
      illegal_n = 0; step(2);
      pulse_load();
      chk("R3", "ME bit ignores level while in_cmd high", status_word[10], 0);
      illegal_n = 1; in_cmd = 0; step();
   endtask

   task automatic t_msg_err();
      new_cmd(0, 0, 0, 0);
      msg_err_evt = 1; step(); msg_err_evt = 0;
      chk("R4", "msg_err_n low after event", msg_err_n, 0);
      step(4);
      chk("R4", "msg_err_n sticky", msg_err_n, 0);
      pulse_load();
      chk("R4", "ME bit from held error", status_word[10], 1);
      new_cmd(0, 0, 0, 0);
      chk("R4", "msg_err_n cleared by new sequence", msg_err_n, 1);
      pulse_load();
      chk("R4", "ME bit clear after new sequence", status_word[10], 0);
   endtask

   task automatic t_dbca();
      new_cmd(0, 1, 1, 0); dbca_n = 0;
      pulse_load();
      chk("R5", "DBCA set on legal DBC mode command", status_word[1], 1);
      dbca_n = 1; pulse_load();
      chk("R5", "DBCA clear with input high", status_word[1], 0);
      new_cmd(0, 1, 0, 0); dbca_n = 0; pulse_load();
      chk("R5", "DBCA clear on other mode code", status_word[1], 0);
      new_cmd(0, 1, 1, 1); pulse_load();
      chk("R5", "DBCA clear on broadcast DBC", status_word[1], 0);
      dbca_n = 1;
   endtask

   task automatic t_bcast();
      new_cmd(0, 0, 0, 1); pulse_load();
      chk("R6", "broadcast bit set", status_word[4], 1);
      new_cmd(0, 0, 0, 0); pulse_load();
      chk("R6", "broadcast bit cleared", status_word[4], 0);
   endtask

   task automatic t_busy();
      busy_n = 0; pulse_load();
      new_cmd(1, 0, 0, 0); xfer_want = 1; step();
      chk("R7", "transmit request blocked by busy", xfer_req_n, 1);
      new_cmd(0, 0, 0, 0);
      chk("R7", "receive request passes with busy", xfer_req_n, 0);
      busy_n = 1; pulse_load();
      new_cmd(1, 0, 0, 0);
      chk("R7", "transmit request passes when not busy", xfer_req_n, 0);
      xfer_want = 0; step();
      chk("R7", "no request without want", xfer_req_n, 1);
   endtask

   task automatic gb_window(input string what, input int exp);
      int lows = 0;
      rx_block_done = 1; step(); rx_block_done = 0;
      for (int i = 0; i < 10; i++) begin
         if (!good_blk_n) lows++;
         step();
      end
      chk("R8", what, lows, exp);
   endtask

   task automatic t_good_blk();
      new_cmd(0, 0, 0, 0);
      gb_window("good block after clean receive", 6);
      new_cmd(1, 0, 0, 0);
      gb_window("no good block on transmit", 0);
      new_cmd(0, 1, 0, 0);
      gb_window("no good block on mode command", 0);
      new_cmd(0, 0, 0, 0);
      msg_err_evt = 1; step(); msg_err_evt = 0;
      gb_window("no good block after message error", 0);
      new_cmd(0, 0, 0, 0);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung, expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; term_addr = '0;
      busy_n = 1; srq_n = 1; ssflag_n = 1; tflag_n = 1; illegal_n = 1; dbca_n = 1;
      in_cmd = 0; cmd_start = 0; cmd_tx = 0; cmd_mode = 0; cmd_dbc = 0; cmd_bcast = 0;
      msg_err_evt = 0; status_load = 0; xfer_want = 0; rx_block_done = 0;
      step(3);
      rst_n = 1;
      step();
      t_reset();
      t_flags();
      t_stat_en();
      t_illegal();
      t_msg_err();
      t_dbca();
      t_bcast();
      t_busy();
      t_good_blk();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule